// File: doc/BRIEF.md
# Leveled Interrupt Request Arbiter

This block gathers interrupt events from a set of peripheral sources. The number of sources is a parameter. Each source owns three pieces of state: a sticky pending flag, an enable bit and a two-bit urgency level. A hardware event pulse raises the pending flag. The flag then stays raised until software clears it. Taking the interrupt does not clear it, and no other action does either.

A small register port lets software program each source's enable bit and level, read them back, read the pending flag, and clear the flag by writing zero to it. On every cycle the block considers each source whose flag and enable are both set. It selects the one with the numerically smallest level. When several share that level, the lowest source index wins. The block presents a valid bit, the winning level and the winning index to the processor on registered outputs. Deciding whether the processor accepts the interrupt is outside this block.

The address is `{source_index, kind}`. Kind 0 is the configuration register. On write, bit 0 is the enable and bits 2:1 are the level; a read returns the same layout. Kind 1 is the pending register. Writing a 0 in bit 0 clears the flag and writing a 1 does nothing. A read returns the flag in bit 0 and zeros in bits 2:1.

Top module: `irq_level_arbiter`

## Requirements
- R1: A one-cycle pulse on `src_evt[i]` sets the pending flag of source i at the next rising clock edge, whatever the enable bit is.
- R2: A pending flag stays set through any number of idle cycles, and through writes of 1 to its pending register. It clears only when software writes 0 to bit 0 of that source's pending register (kind 1).
- R3: A pending source whose enable bit is 0 never appears on the outputs, but its flag can still be read as 1.
- R4: Among the sources that are both pending and enabled, the presented level is the numerically smallest one; level 0 is the most urgent, and level 3 is still delivered.
- R5: When several eligible sources share the smallest level, the presented index is the lowest of them.
- R6: If an event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R7: The outputs are registered. After a clock edge that changes flags or configuration, they still hold their old values until the following edge, and then reflect the new state. When nothing is eligible, `irq_valid`, `irq_level` and `irq_src` are all 0.
- R8: A write to the configuration register (kind 0) sets the enable from bit 0 and the level from bits 2:1, and the same register reads back those values.
- R9: After reset every flag and enable bit is 0, every level is 3, and the outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | N_SRC | One-cycle event pulse from each source |
| reg_addr | input | $clog2(N_SRC)+1 | Register address `{source, kind}` |
| reg_we | input | 1 | Write strobe for `reg_addr` |
| reg_wdata | input | LVL_W+1 | Write data |
| reg_rdata | output | LVL_W+1 | Combinational read data for `reg_addr` |
| irq_valid | output | 1 | Some enabled source is pending |
| irq_level | output | LVL_W | Level of the winning source |
| irq_src | output | $clog2(N_SRC) | Index of the winning source |

## Verification
The bench first raises a flag on a disabled source, to tell an event path apart from an enable path. It then enables sources one at a time at different levels, so a wrong level comparison shows up as a wrong winner. Next it raises two sources at the same level together; this separates the lowest-index rule from an accidental highest-index or last-written rule. Single-cycle collisions of an event and a clear, writes of 1 to a pending flag, and the cycle right after each change separate sticky flags and registered timing from sources that clear too eagerly or from a comparison that is not registered.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   localparam int unsigned LVL_W = 2;
   localparam int unsigned DATA_W = LVL_W + 1;

   typedef logic [LVL_W-1:0] lvl_t;

   // register kinds selected by the address LSB
   typedef enum logic {
      KIND_CFG  = 1'b0,
      KIND_PEND = 1'b1
   } reg_kind_e;

   // true when candidate b must replace incumbent a (lower level only)
   function automatic logic lvl_beats(input lvl_t b, input lvl_t a);
      return b < a;
   endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
   import irq_arb_pkg::*;
#(
   parameter lvl_t LVL_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic              cfg_we,
   input  logic              pend_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              flag_q,
   output logic              en_q,
   output lvl_t              lvl_q
);

   logic clr;
   assign clr = pend_we && !wdata[0];

   // event has precedence over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (evt)   flag_q <= 1'b1;
      else if (clr)   flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         lvl_q <= LVL_RST;
      end else if (cfg_we) begin
         en_q  <= wdata[0];
         lvl_q <= wdata[DATA_W-1:1];
      end
   end

   a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag_q);

   a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);

   a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && clr) |=> flag_q);

   a_r8_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (en_q == $past(wdata[0]) && lvl_q == $past(wdata[DATA_W-1:1])));

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
   import irq_arb_pkg::*;
#(
   parameter int unsigned N_SRC    = 8,
   parameter bit          USE_TREE = 1'b1,
   localparam int unsigned IDX_W   = $clog2(N_SRC),
   localparam int unsigned N_PAD   = 1 << IDX_W
) (
   input  logic [N_SRC-1:0] elig,
   input  lvl_t             lvl [N_SRC],
   output logic             win_valid,
   output lvl_t             win_lvl,
   output logic [IDX_W-1:0] win_idx
);

   generate
      if (USE_TREE) begin : g_tree
         logic             nv [2*N_PAD-1];
         lvl_t             nl [2*N_PAD-1];
         logic [IDX_W-1:0] ni [2*N_PAD-1];

         always_comb begin
            for (int i = 0; i < N_PAD; i++) begin
               if (i < N_SRC) begin
                  nv[N_PAD-1+i] = elig[i];
                  nl[N_PAD-1+i] = lvl[i];
               end else begin
                  nv[N_PAD-1+i] = 1'b0;
                  nl[N_PAD-1+i] = '1;
               end
               ni[N_PAD-1+i] = IDX_W'(i);
            end
            // left child holds lower indices, so it keeps ties
            for (int k = N_PAD-2; k >= 0; k--) begin
               if (nv[2*k+2] && (!nv[2*k+1] || lvl_beats(nl[2*k+2], nl[2*k+1]))) begin
                  nv[k] = 1'b1;
                  nl[k] = nl[2*k+2];
                  ni[k] = ni[2*k+2];
               end else begin
                  nv[k] = nv[2*k+1];
                  nl[k] = nl[2*k+1];
                  ni[k] = ni[2*k+1];
               end
            end
         end

         assign win_valid = nv[0];
         assign win_lvl   = nv[0] ? nl[0] : '0;
         assign win_idx   = nv[0] ? ni[0] : '0;
      end else begin : g_scan
         always_comb begin
            win_valid = 1'b0;
            win_lvl   = '0;
            win_idx   = '0;
            // scan downward; "not worse" lets lower index take ties
            for (int i = N_SRC-1; i >= 0; i--) begin
               if (elig[i] && (!win_valid || !lvl_beats(win_lvl, lvl[i]))) begin
                  win_valid = 1'b1;
                  win_lvl   = lvl[i];
                  win_idx   = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned N_SRC    = 8,
   parameter bit          USE_TREE = 1'b1,
   localparam int unsigned IDX_W   = $clog2(N_SRC),
   localparam int unsigned ADDR_W  = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_evt,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_valid,
   output logic [LVL_W-1:0]  irq_level,
   output logic [IDX_W-1:0]  irq_src
);

   generate
      if (N_SRC < 2) begin : g_bad_n
         $error("N_SRC must be at least 2");
      end
      if (N_SRC > 256) begin : g_big_n
         $error("N_SRC above 256 is not supported");
      end
   endgenerate

   logic [N_SRC-1:0] flag_v, en_v, elig_v;
   lvl_t             lvl_v [N_SRC];
   logic [IDX_W-1:0] sel_src;
   reg_kind_e        sel_kind;

   assign sel_src  = reg_addr[ADDR_W-1:1];
   assign sel_kind = reg_kind_e'(reg_addr[0]);

   for (genvar i = 0; i < N_SRC; i++) begin : g_slot
      logic hit;
      assign hit = reg_we && (sel_src == IDX_W'(i));
      irq_src_slot u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (src_evt[i]),
         .cfg_we  (hit && sel_kind == KIND_CFG),
         .pend_we (hit && sel_kind == KIND_PEND),
         .wdata   (reg_wdata),
         .flag_q  (flag_v[i]),
         .en_q    (en_v[i]),
         .lvl_q   (lvl_v[i])
      );
   end

   assign elig_v = flag_v & en_v;

   always_comb begin
      reg_rdata = '0;
      if (int'(sel_src) < N_SRC) begin
         if (sel_kind == KIND_CFG) reg_rdata = {lvl_v[sel_src], en_v[sel_src]};
         else                      reg_rdata[0] = flag_v[sel_src];
      end
   end

   logic             w_valid;
   lvl_t             w_lvl;
   logic [IDX_W-1:0] w_idx;

   irq_prio_select #(.N_SRC(N_SRC), .USE_TREE(USE_TREE)) u_sel (
      .elig      (elig_v),
      .lvl       (lvl_v),
      .win_valid (w_valid),
      .win_lvl   (w_lvl),
      .win_idx   (w_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid <= 1'b0;
         irq_level <= '0;
         irq_src   <= '0;
      end else begin
         irq_valid <= w_valid;
         irq_level <= w_lvl;
         irq_src   <= w_idx;
      end
   end

   // checker state: previous eligibility and an independent judgement of it
   logic [N_SRC-1:0] elig_d;
   lvl_t             lvl_d [N_SRC];
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) elig_d <= '0;
      else        elig_d <= elig_v;
   end
   always_ff @(posedge clk) lvl_d <= lvl_v;

   function automatic logic out_is_best(input logic [IDX_W-1:0] s, input lvl_t l);
      logic ok;
      ok = elig_d[s] && (lvl_d[s] == l);
      for (int j = 0; j < N_SRC; j++) begin
         if (elig_d[j] && lvl_d[j] < l) ok = 1'b0;
         if (elig_d[j] && lvl_d[j] == l && j < int'(s)) ok = 1'b0;
      end
      return ok;
   endfunction

   a_r3_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> elig_d[irq_src]);

   a_r4_r5_best_choice: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> out_is_best(irq_src, irq_level));

   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_level == '0 && irq_src == '0 && elig_d == '0));

endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int IW = $clog2(N);
   localparam int AW = IW + 1;
   localparam int DW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_evt = '0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_valid;
   logic [1:0]    irq_level;
   logic [IW-1:0] irq_src;

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct {
      logic       v;
      logic [1:0] l;
      int         s;
      string      tag;
   } exp_t;
   exp_t q[$];

   irq_level_arbiter #(.N_SRC(N)) u_irq_level_arbiter (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_valid(irq_valid), .irq_level(irq_level), .irq_src(irq_src)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: pops expected items at the falling edge and compares
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (irq_valid !== e.v || irq_level !== e.l || int'(irq_src) != e.s) begin
               bad++;
               $display("FAIL %s: got v=%0b l=%0d s=%0d exp v=%0b l=%0d s=%0d",
                        e.tag, irq_valid, irq_level, irq_src, e.v, e.l, e.s);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD*20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // all drive tasks start and end at a falling edge
   task automatic pulse(input logic [N-1:0] ev, input bit we, input int src,
                        input bit kind, input logic [DW-1:0] d);
      src_evt   = ev;
      reg_we    = we;
      reg_addr  = AW'({src[IW-1:0], kind});
      reg_wdata = d;
      @(negedge clk);
      src_evt = '0;
      reg_we  = 1'b0;
   endtask

   task automatic expect_out(input logic v, input logic [1:0] l, input int s, input string tag);
      @(posedge clk);
      q.push_back('{v: v, l: l, s: s, tag: tag});
      @(negedge clk);
   endtask

   task automatic hold_check(input logic v, input logic [1:0] l, input int s, input string tag);
      total++;
      if (irq_valid !== v || irq_level !== l || int'(irq_src) != s) begin
         bad++;
         $display("FAIL %s: got v=%0b l=%0d s=%0d exp v=%0b l=%0d s=%0d",
                  tag, irq_valid, irq_level, irq_src, v, l, s);
      end
   endtask

   task automatic rd_check(input int src, input bit kind, input logic [DW-1:0] e, input string tag);
      reg_addr = AW'({src[IW-1:0], kind});
      #1;
      total++;
      if (reg_rdata !== e) begin
         bad++;
         $display("FAIL %s: got rdata=%0h exp %0h", tag, reg_rdata, e);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      hold_check(0, 0, 0, "R9 outputs after reset");
      rd_check(0, 0, 3'b110, "R9 cfg src0 reset");
      rd_check(7, 1, 3'b000, "R9 flag src7 reset");

      // R1/R3: flag set on disabled source, nothing presented
      pulse(8'h20, 0, 0, 0, 0);
      rd_check(5, 1, 3'b001, "R1 flag5 set");
      expect_out(0, 0, 0, "R3 disabled not shown");

      // R8 enable src5 at level 2; R7 one-cycle lag
      pulse('0, 1, 5, 0, 3'b101);
      rd_check(5, 0, 3'b101, "R8 cfg5 readback");
      hold_check(0, 0, 0, "R7 old value held");
      expect_out(1, 2, 5, "R7 src5 lvl2 after lag");

      // R4 more urgent level wins
      pulse('0, 1, 2, 0, 3'b011);
      expect_out(1, 2, 5, "R4 src2 cfg only, no flag");
      pulse(8'h04, 0, 0, 0, 0);
      hold_check(1, 2, 5, "R7 hold before src2 shows");
      expect_out(1, 1, 2, "R4 src2 lvl1 wins");

      // R5 tie at level 1: src6 and src3 together, src2 still lowest
      pulse('0, 1, 6, 0, 3'b011);
      pulse('0, 1, 3, 0, 3'b011);
      pulse(8'h48, 0, 0, 0, 0);
      expect_out(1, 1, 2, "R5 tie lowest src2");

      // R2 clear src2, tie between 3 and 6 -> 3
      pulse('0, 1, 2, 1, 3'b000);
      rd_check(2, 1, 3'b000, "R2 flag2 cleared");
      expect_out(1, 1, 3, "R5 tie picks src3");
      pulse('0, 1, 3, 1, 3'b000);
      expect_out(1, 1, 6, "R2 after clear src6");

      // R2 writing 1 has no effect; idle cycles keep flag
      pulse('0, 1, 6, 1, 3'b001);
      repeat (5) @(negedge clk);
      rd_check(6, 1, 3'b001, "R2 flag6 sticky");
      expect_out(1, 1, 6, "R2 src6 still shown");

      // R6 event and clear collide on src6
      pulse(8'h40, 1, 6, 1, 3'b000);
      rd_check(6, 1, 3'b001, "R6 flag6 survives");
      expect_out(1, 1, 6, "R6 src6 still shown");

      // drop src6 -> src5 level 2; then raise src5 to level 0
      pulse('0, 1, 6, 1, 3'b000);
      expect_out(1, 2, 5, "R4 back to src5");
      pulse('0, 1, 5, 0, 3'b001);
      expect_out(1, 0, 5, "R4 src5 lvl0");

      // R3 disable src5, flag readable, nothing presented
      pulse('0, 1, 5, 0, 3'b000);
      expect_out(0, 0, 0, "R3 src5 disabled idle");
      rd_check(5, 1, 3'b001, "R3 flag5 kept");

      // R4 level 3 is still delivered
      pulse('0, 1, 7, 0, 3'b111);
      pulse(8'h80, 0, 0, 0, 0);
      expect_out(1, 3, 7, "R4 lvl3 delivered");
      pulse('0, 1, 1, 0, 3'b111);
      pulse(8'h02, 0, 0, 0, 0);
      expect_out(1, 3, 1, "R5 lvl3 tie src1");

      repeat (2) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule